// File: doc/BRIEF.md
# Memory Card Host Register Front End

This block sits on a CPU's register bus and lets software run a memory card's command line and a single data line. It transfers one byte or one word per access. Software sets the card clock rate and turns on each of four channels on its own: command send, command receive, data send and data receive. It starts transfers through a trigger register and watches progress in a pending register. The block makes the card clock itself. It shifts outgoing bits on the falling card-clock edge and samples incoming bits on the rising edge.

A command goes out one byte at a time. Software writes the byte into the command register, then sets the command-send trigger. A data word goes out as soon as it is written to the data register. A command byte coming back is framed by the first low bit the card drives. A data word is captured after software sets the data-receive trigger. Received values stay put until the next capture, and their pending flags stay set until software writes ones to clear them. When no card is inserted, the block answers command and data reads with all ones and drops writes to those two registers.

Top module: `sdcard_host_regs`

## Requirements
- R1: After reset, every register offset reads zero while a card is present. The card clock output is low, and both serial outputs are high.
- R2: The register index is address bits [4:2], with this layout: 0 clock divider, 1 channel enable, 2 pending, 3 start, 4 command byte, 5 data word. Read data appears on the bus in the cycle after the read strobe. Offsets 6 and 7 read zero, and writes to them change nothing.
- R3: The card clock toggles every div+1 system cycles, so its period is 2×(div+1), where div is the low DIV_W bits of offset 0.
- R4: Enable bit 0 gates command send, bit 1 command receive, bit 2 data send and bit 3 data receive. The start register reads back the two bits last written to it. Writing 1 to start bit 0 launches a command send only when enable bit 0 is set, a card is present and no command send is already running; otherwise the line stays high.
- R5: A command send shifts out the byte last written to the low 8 bits of offset 4, MSB first, driving each bit at a falling card-clock edge. Pending bit 0 reads 1 from the launch until the rising edge that samples the 8th bit. The line returns high at the next falling edge.
- R6: A write to offset 5 launches a 32-bit send, MSB first, when enable bit 2 is set, a card is present and no data send is running. Pending bit 2 reads 1 until the rising edge that samples the 32nd bit.
- R7: With enable bit 1 set and pending bit 1 clear, a rising-edge sample of 0 on the command input becomes the MSB of a byte, and the next 7 rising-edge samples complete it. Pending bit 1 is then set, and offset 4 reads the byte in its low 8 bits. No byte is captured while pending bit 1 is set.
- R8: Writing 1 to start bit 1, with enable bit 3 set and a card present, captures the next 32 rising-edge samples of the data input, MSB first. Pending bit 3 is then set, and offset 5 reads the word.
- R9: Writing 1 to pending bit 1 or bit 3 clears that flag, and writing 0 leaves it unchanged. Pending bits 0 and 2 are not affected by writes.
- R10: With no card present, offset 4 reads 0xFF and offset 5 reads 0xFFFFFFFF. Writes to offsets 4 and 5 are ignored and leave the held command byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| card_present | input | 1 | High while a card is inserted |
| card_sck | output | 1 | Card clock |
| cmd_out | output | 1 | Serial command line to the card |
| cmd_in | input | 1 | Serial command line from the card |
| dat_out | output | 1 | Serial data line to the card |
| dat_in | input | 1 | Serial data line from the card |

## Verification
The assertions assume one bus access per cycle, never a read and a write together. They also assume reset is held for a few cycles, so the clock generator starts from a known phase before any property is checked. The serial inputs must change only between rising card-clock edges. The stimulus keeps to this by changing the command and data inputs right after a falling edge of card_sck, and by issuing every bus strobe on the falling system-clock edge for a single cycle.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
  localparam int BUS_W = 32;
  localparam int CMD_W = 8;
  localparam int NCH   = 4;

  localparam logic [2:0] IX_DIV  = 3'd0;
  localparam logic [2:0] IX_ENA  = 3'd1;
  localparam logic [2:0] IX_PEND = 3'd2;
  localparam logic [2:0] IX_GO   = 3'd3;
  localparam logic [2:0] IX_CMD  = 3'd4;
  localparam logic [2:0] IX_DAT  = 3'd5;

  localparam int CH_CTX = 0;
  localparam int CH_CRX = 1;
  localparam int CH_DTX = 2;
  localparam int CH_DRX = 3;

  localparam int GO_CTX = 0;
  localparam int GO_DRX = 1;
endpackage

// File: rtl/sdh_clkgen.sv
module sdh_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             fall_evt,
  output logic             rise_evt
);
  logic [DIV_W-1:0] cnt;
  logic             hit;

  assign hit      = (cnt >= div);
  assign fall_evt = hit & sck;
  assign rise_evt = hit & ~sck;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (hit) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  sck_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sck) |-> $past(fall_evt || rise_evt));
endmodule

// File: rtl/sdh_txshift.sv
module sdh_txshift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         launch,
  input  logic [W-1:0] word,
  input  logic         fall_evt,
  input  logic         rise_evt,
  output logic         line,
  output logic         busy
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0]  sr;
  logic [CW-1:0] sent;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      sent <= '0;
      busy <= 1'b0;
      line <= 1'b1;
    end else if (launch) begin
      sr   <= word;
      sent <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      if (fall_evt && sent != FULL) begin
        line <= sr[W-1];
        sr   <= {sr[W-2:0], 1'b0};
        sent <= sent + 1'b1;
      end else if (rise_evt && sent == FULL) begin
        busy <= 1'b0;
      end
    end else if (fall_evt) begin
      line <= 1'b1;
    end
  end

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(rise_evt));

  // R6
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(fall_evt) |-> $stable(line));
endmodule

// File: rtl/sdh_rxshift.sv
module sdh_rxshift #(
  parameter int W    = 8,
  parameter bit HUNT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm,
  input  logic         kick,
  input  logic         line,
  input  logic         rise_evt,
  output logic [W-1:0] word,
  output logic         done
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] GOT0 = HUNT ? CW'(1) : '0;

  logic [W-1:0]  sr;
  logic [CW-1:0] got;
  logic          active;
  logic          begin_now;

  generate
    if (HUNT) begin : g_hunt
      logic unused_kick;
      assign unused_kick = kick;
      assign begin_now   = arm & rise_evt & ~line;
    end else begin : g_kick
      assign begin_now = arm & kick;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      got    <= '0;
      active <= 1'b0;
      word   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (begin_now) begin
          active <= 1'b1;
          got    <= GOT0;
          sr     <= '0;
        end
      end else if (rise_evt) begin
        sr <= {sr[W-2:0], line};
        if (got == LAST) begin
          active <= 1'b0;
          got    <= '0;
          word   <= {sr[W-2:0], line};
          done   <= 1'b1;
        end else begin
          got <= got + 1'b1;
        end
      end
    end
  end

  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(rise_evt));

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(word) |-> done);
endmodule

// File: rtl/sdcard_host_regs.sv
module sdcard_host_regs
  import sdh_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              card_present,
  output logic              card_sck,
  output logic              cmd_out,
  input  logic              cmd_in,
  output logic              dat_out,
  input  logic              dat_in
);
  logic [2:0]       idx;
  logic [DIV_W-1:0] div_q;
  logic [NCH-1:0]   ena_q;
  logic [1:0]       go_q;
  logic [CMD_W-1:0] cmd_hold;
  logic             pend_crx, pend_drx;
  logic             fall_evt, rise_evt;
  logic             ctx_busy, dtx_busy;
  logic             ctx_launch, dtx_launch, drx_kick;
  logic             crx_done, drx_done;
  logic [CMD_W-1:0] crx_word;
  logic [BUS_W-1:0] drx_word;
  logic             unused_addr;

  assign idx         = bus_addr[4:2];
  assign unused_addr = ^bus_addr;

  assign ctx_launch = bus_wr && idx == IX_GO && bus_wdata[GO_CTX] &&
                      ena_q[CH_CTX] && card_present && !ctx_busy;
  assign dtx_launch = bus_wr && idx == IX_DAT &&
                      ena_q[CH_DTX] && card_present && !dtx_busy;
  assign drx_kick   = bus_wr && idx == IX_GO && bus_wdata[GO_DRX];

  sdh_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .div(div_q),
    .sck(card_sck), .fall_evt(fall_evt), .rise_evt(rise_evt)
  );

  sdh_txshift #(.W(CMD_W)) u_ctx (
    .clk(clk), .rst(rst), .launch(ctx_launch), .word(cmd_hold),
    .fall_evt(fall_evt), .rise_evt(rise_evt), .line(cmd_out), .busy(ctx_busy)
  );

  sdh_txshift #(.W(BUS_W)) u_dtx (
    .clk(clk), .rst(rst), .launch(dtx_launch), .word(bus_wdata),
    .fall_evt(fall_evt), .rise_evt(rise_evt), .line(dat_out), .busy(dtx_busy)
  );

  sdh_rxshift #(.W(CMD_W), .HUNT(1'b1)) u_crx (
    .clk(clk), .rst(rst),
    .arm(ena_q[CH_CRX] && card_present && !pend_crx), .kick(1'b0),
    .line(cmd_in), .rise_evt(rise_evt), .word(crx_word), .done(crx_done)
  );

  sdh_rxshift #(.W(BUS_W), .HUNT(1'b0)) u_drx (
    .clk(clk), .rst(rst),
    .arm(ena_q[CH_DRX] && card_present), .kick(drx_kick),
    .line(dat_in), .rise_evt(rise_evt), .word(drx_word), .done(drx_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      ena_q    <= '0;
      go_q     <= '0;
      cmd_hold <= '0;
    end else if (bus_wr) begin
      case (idx)
        IX_DIV: div_q <= bus_wdata[DIV_W-1:0];
        IX_ENA: ena_q <= bus_wdata[NCH-1:0];
        IX_GO:  go_q  <= bus_wdata[1:0];
        IX_CMD: if (card_present) cmd_hold <= bus_wdata[CMD_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_crx <= 1'b0;
      pend_drx <= 1'b0;
    end else begin
      if (crx_done)
        pend_crx <= 1'b1;
      else if (bus_wr && idx == IX_PEND && bus_wdata[CH_CRX])
        pend_crx <= 1'b0;
      if (drx_done)
        pend_drx <= 1'b1;
      else if (bus_wr && idx == IX_PEND && bus_wdata[CH_DRX])
        pend_drx <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (idx)
        IX_DIV:  bus_rdata <= BUS_W'(div_q);
        IX_ENA:  bus_rdata <= BUS_W'(ena_q);
        IX_PEND: bus_rdata <= BUS_W'({pend_drx, dtx_busy, pend_crx, ctx_busy});
        IX_GO:   bus_rdata <= BUS_W'(go_q);
        IX_CMD:  bus_rdata <= card_present ? BUS_W'(crx_word) : BUS_W'(8'hFF);
        IX_DAT:  bus_rdata <= card_present ? drx_word : '1;
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R10
  absent_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && idx == IX_CMD && !card_present) |=> (bus_rdata == 32'h0000_00FF));

  // R10
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == IX_CMD && !card_present) |=> $stable(cmd_hold));

  // R9
  clear_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_crx) |-> $past(bus_wr && idx == IX_PEND && bus_wdata[CH_CRX]));
endmodule

// File: tb/sdcard_host_regs_bench.sv
module sdcard_host_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        card_present = 1'b1;
  logic        card_sck, cmd_out, dat_out;
  logic        cmd_in = 1'b1, dat_in = 1'b1;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sdcard_host_regs u_sdcard_host_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_present(card_present),
    .card_sck(card_sck), .cmd_out(cmd_out), .cmd_in(cmd_in),
    .dat_out(dat_out), .dat_in(dat_in)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference for the card clock and both output lines
  int  m_div, m_cnt;
  bit  m_sck, m_cmd, m_dat, m_cb, m_db, m_hit, m_fe, m_re, m_lc, m_ld;
  bit [3:0] m_en;
  bit [7:0] m_hold;
  bit cq[$];
  bit dq[$];

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_div = 0; m_cnt = 0; m_sck = 0; m_cmd = 1; m_dat = 1;
      m_cb = 0; m_db = 0; m_en = 0; m_hold = 0;
      cq.delete(); dq.delete();
    end else begin
      m_hit = (m_cnt >= m_div);
      m_fe  = m_hit && m_sck;
      m_re  = m_hit && !m_sck;
      m_lc  = bus_wr && bus_addr[4:2] == 3 && bus_wdata[0] && m_en[0] && card_present && !m_cb;
      m_ld  = bus_wr && bus_addr[4:2] == 5 && m_en[2] && card_present && !m_db;
      if (m_lc) begin
        cq.delete();
        for (int i = 7; i >= 0; i--) cq.push_back(m_hold[i]);
        m_cb = 1;
      end else if (m_cb) begin
        if (m_fe && cq.size() != 0) m_cmd = cq.pop_front();
        else if (m_re && cq.size() == 0) m_cb = 0;
      end else if (m_fe) m_cmd = 1;
      if (m_ld) begin
        dq.delete();
        for (int i = 31; i >= 0; i--) dq.push_back(bus_wdata[i]);
        m_db = 1;
      end else if (m_db) begin
        if (m_fe && dq.size() != 0) m_dat = dq.pop_front();
        else if (m_re && dq.size() == 0) m_db = 0;
      end else if (m_fe) m_dat = 1;
      if (m_hit) begin m_cnt = 0; m_sck = !m_sck; end
      else m_cnt++;
      if (bus_wr) begin
        case (bus_addr[4:2])
          3'd0: m_div = int'(bus_wdata[7:0]);
          3'd1: m_en = bus_wdata[3:0];
          3'd4: if (card_present) m_hold = bus_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  // R3 R5 R6: clock and serial outputs against the reference every cycle
  always @(negedge clk) begin
    if (!rst && !finished)
      chk("R3/R5/R6 lines", {29'd0, card_sck, cmd_out, dat_out}, {29'd0, m_sck, m_cmd, m_dat});
  end

  task automatic wr(input int ix, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(ix << 2); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int ix, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(ix << 2); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_cmd_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge card_sck);
      cmd_in = b[i];
    end
    @(negedge card_sck);
    cmd_in = 1'b1;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int t0, t1;
    logic [31:0] rxw;
    rxw = 32'h9E37_4C21;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 sck", {31'd0, card_sck}, 32'd0);
    chk("R1 lines", {30'd0, cmd_out, dat_out}, 32'd3);
    for (int k = 0; k < 8; k++) begin
      rd(k, v);
      chk("R1 R2 reset read", v, 32'd0);
    end

    // R2 decode and dead offsets
    wr(0, 32'd2);
    rd(0, v); chk("R2 divider readback", v, 32'd2);
    wr(6, 32'hDEAD_BEEF);
    rd(6, v); chk("R2 offset 6", v, 32'd0);
    rd(0, v); chk("R2 divider unchanged", v, 32'd2);

    // R3 period
    @(posedge card_sck); t0 = cyc;
    @(posedge card_sck); t1 = cyc;
    chk("R3 period", 32'(t1 - t0), 32'd6);

    // R4 enable and start readback, R5 command send
    wr(1, 32'h5);
    rd(1, v); chk("R4 enable readback", v, 32'h5);
    wr(4, 32'h5A);
    wr(3, 32'h1);
    rd(3, v); chk("R4 start readback", v, 32'h1);
    wr(2, 32'h5);
    rd(2, v); chk("R5 R9 tx pending busy", v, 32'h1);
    repeat (80) @(negedge clk);
    rd(2, v); chk("R5 tx pending done", v, 32'h0);

    // R6 data send
    wr(5, 32'hC3A5_0F96);
    rd(2, v); chk("R6 data pending busy", v, 32'h4);
    repeat (240) @(negedge clk);
    rd(2, v); chk("R6 data pending done", v, 32'h0);

    // R4 launch blocked by enable
    wr(1, 32'h0);
    wr(3, 32'h1);
    rd(2, v); chk("R4 gated launch", v, 32'h0);
    repeat (30) @(negedge clk);

    // R10 absent card
    wr(1, 32'h5);
    card_present = 1'b0;
    rd(4, v); chk("R10 cmd absent", v, 32'h0000_00FF);
    rd(5, v); chk("R10 dat absent", v, 32'hFFFF_FFFF);
    wr(4, 32'h11);
    wr(5, 32'h1234_5678);
    rd(2, v); chk("R10 dat write ignored", v, 32'h0);
    card_present = 1'b1;
    wr(3, 32'h1);
    repeat (80) @(negedge clk);
    rd(2, v); chk("R10 held byte resent", v, 32'h0);

    // R7 command receive
    wr(1, 32'h2);
    send_cmd_byte(8'h3B);
    repeat (10) @(negedge clk);
    rd(2, v); chk("R7 rx pending", v, 32'h2);
    rd(4, v); chk("R7 rx byte", v, 32'h3B);
    send_cmd_byte(8'h15);
    repeat (10) @(negedge clk);
    rd(4, v); chk("R7 no capture while pending", v, 32'h3B);
    wr(2, 32'h0);
    rd(2, v); chk("R9 zero write keeps", v, 32'h2);
    wr(2, 32'h2);
    rd(2, v); chk("R9 clear", v, 32'h0);
    send_cmd_byte(8'h62);
    repeat (10) @(negedge clk);
    rd(4, v); chk("R7 second byte", v, 32'h62);
    wr(2, 32'h2);

    // R8 data receive
    wr(1, 32'h8);
    @(negedge card_sck);
    dat_in = rxw[31];
    wr(3, 32'h2);
    for (int i = 30; i >= 0; i--) begin
      @(negedge card_sck);
      dat_in = rxw[i];
    end
    @(negedge card_sck);
    dat_in = 1'b1;
    repeat (10) @(negedge clk);
    rd(2, v); chk("R8 rx pending", v, 32'h8);
    rd(5, v); chk("R8 rx word", v, rxw);
    wr(2, 32'h8);
    rd(2, v); chk("R9 data clear", v, 32'h0);

    finish_run();
  end
endmodule